// File: doc/BRIEF.md
# Serial Port Channel Register Front End

This block is the register side of one serial port channel. A processor reaches it over a simple synchronous bus with an address, a write strobe with write data, and a read strobe with read data. It holds eleven 32-bit registers: line setup, channel control, queue setup, modem setup, transfer status, error status, queue status, modem status, transmit holding, receive holding and baud divisor. The serial shifter, the data queues and the modem pins live elsewhere.

Accesses to the holding registers have side effects. A transmit write marks the transmitter as idle and raises the transmit interrupt. In loopback mode the same write also lands in the receive holding register, marks receive data as ready and raises the receive interrupt. A read of the receive holding register withdraws the ready flag. Each interrupt line is either held as a level or fired as a one-cycle pulse, chosen by a control bit. A divider makes a 16x oversample tick from one of two clock enables.

Top module: `uartif_top`

## Requirements
- R1: After reset the transfer status register reads 0x0000_0006, every other register reads zero, and both interrupt outputs are low.
- R2: The registers sit at word offsets 0x00 line setup, 0x04 control, 0x08 queue setup, 0x0C modem setup, 0x10 transfer status, 0x14 error status, 0x18 queue status, 0x1C modem status, 0x20 transmit holding, 0x24 receive holding and 0x28 divisor. Each one keeps the full word last written to it. Read data shows the addressed register in the same cycle as the read strobe.
- R3: A read of an unaligned offset, or of an offset above 0x28, returns 0xFFFF_FFFF. A write to such an offset changes no register.
- R4: A read of the receive holding register clears status bit 0 (receive ready). When control bit 8 is 1, the same read also drops a held receive interrupt.
- R5: A write to the transmit holding register sets status bits 1 (holding empty) and 2 (transmitter empty). It also raises the transmit interrupt: as a level held from the next cycle when control bit 9 is 1, or as a high pulse for exactly the next cycle when control bit 9 is 0.
- R6: With control bit 5 (loopback) at 1, a transmit holding write also copies the data into the receive holding register and sets status bit 0. It raises the receive interrupt as a held level if control bit 8 is 1, or as a one-cycle pulse if control bit 8 is 0.
- R7: A control write with bit 9 at 1 raises the transmit interrupt as a held level, and one with bit 9 at 0 drops it. A control write with bit 8 at 1 drops a held receive interrupt. One with bit 8 at 0 leaves the held receive interrupt alone.
- R8: One baud tick is issued for every (divisor[15:0] + 1) cycles in which the selected clock enable is high. Control bit 10 at 1 selects the external enable and at 0 selects the bus clock enable.
- R9: Each write to the divisor register restarts the tick count, so that the next tick comes only after a full (divisor + 1) enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pclk_en | input | 1 | Bus-clock-derived baud enable |
| extclk_en | input | 1 | External-clock-derived baud enable |
| baud_tick | output | 1 | 16x oversample tick, one cycle wide |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
Most faults in the status or holding state show up on the first read of transfer status or receive holding after the access that should have changed them. A held interrupt flag that sets or clears at the wrong time shows on irq_tx or irq_rx one cycle after the write or read that moved it. A mix-up between pulse and level shows one cycle later, when the line fails to drop or to stay high. A fault in the divider count or its restart shows as a shifted or missing tick within one divisor period. A fault in the choice of clock enable shows as a wrong tick count over a fixed window.

// File: rtl/uartif_pkg.sv
package uartif_pkg;
  localparam int unsigned NREG = 11;

  localparam int unsigned IDX_LINE  = 0;
  localparam int unsigned IDX_CTRL  = 1;
  localparam int unsigned IDX_QCFG  = 2;
  localparam int unsigned IDX_MCFG  = 3;
  localparam int unsigned IDX_STAT  = 4;
  localparam int unsigned IDX_ERR   = 5;
  localparam int unsigned IDX_QSTAT = 6;
  localparam int unsigned IDX_MSTAT = 7;
  localparam int unsigned IDX_TXH   = 8;
  localparam int unsigned IDX_RXH   = 9;
  localparam int unsigned IDX_DIV   = 10;

  localparam int unsigned CB_LOOP   = 5;
  localparam int unsigned CB_RXLVL  = 8;
  localparam int unsigned CB_TXLVL  = 9;
  localparam int unsigned CB_EXTCLK = 10;

  localparam int unsigned SB_RXRDY  = 0;
  localparam int unsigned SB_TXBE   = 1;
  localparam int unsigned SB_TXE    = 2;

  localparam int unsigned NIRQ   = 2;
  localparam int unsigned IRQ_TX = 0;
  localparam int unsigned IRQ_RX = 1;
endpackage

// File: rtl/uartif_regs.sv
module uartif_regs
  import uartif_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              div_wr_o,
  output logic [NIRQ-1:0]   set_lvl_o,
  output logic [NIRQ-1:0]   set_pls_o,
  output logic [NIRQ-1:0]   clr_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = $clog2(NREG);
  localparam logic [WORD_W-1:0] NREG_W = WORD_W'(NREG);
  localparam logic [DATA_W-1:0] STAT_RST =
    DATA_W'((1 << SB_TXBE) | (1 << SB_TXE));

  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] regs_d [NREG];
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  idx;
  logic              hit, wr_hit, rd_hit;
  logic              tx_wr, rx_rd, ctl_wr, loop_on;

  assign word   = addr[ADDR_W-1:2];
  assign hit    = (addr[1:0] == 2'b00) && (word < NREG_W);
  assign idx    = word[IDX_W-1:0];
  assign wr_hit = wr && hit;
  assign rd_hit = rd && hit;
  assign tx_wr  = wr_hit && (idx == IDX_W'(IDX_TXH));
  assign rx_rd  = rd_hit && (idx == IDX_W'(IDX_RXH));
  assign ctl_wr = wr_hit && (idx == IDX_W'(IDX_CTRL));
  assign loop_on = regs_q[IDX_CTRL][CB_LOOP];

  always_comb begin
    for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
    if (wr_hit) regs_d[idx] = wdata;
    if (rx_rd) regs_d[IDX_STAT][SB_RXRDY] = 1'b0;
    if (tx_wr) begin
      regs_d[IDX_STAT][SB_TXBE] = 1'b1;
      regs_d[IDX_STAT][SB_TXE]  = 1'b1;
      if (loop_on) begin
        regs_d[IDX_RXH]            = wdata;
        regs_d[IDX_STAT][SB_RXRDY] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs_q[i] <= (i == IDX_STAT) ? STAT_RST : '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
    end
  end

  always_comb begin
    set_lvl_o[IRQ_TX] = (tx_wr && regs_q[IDX_CTRL][CB_TXLVL]) ||
                        (ctl_wr && wdata[CB_TXLVL]);
    set_pls_o[IRQ_TX] = tx_wr && !regs_q[IDX_CTRL][CB_TXLVL];
    clr_o[IRQ_TX]     = ctl_wr && !wdata[CB_TXLVL];
    set_lvl_o[IRQ_RX] = tx_wr && loop_on && regs_q[IDX_CTRL][CB_RXLVL];
    set_pls_o[IRQ_RX] = tx_wr && loop_on && !regs_q[IDX_CTRL][CB_RXLVL];
    clr_o[IRQ_RX]     = (rx_rd && regs_q[IDX_CTRL][CB_RXLVL]) ||
                        (ctl_wr && wdata[CB_RXLVL]);
  end

  assign rdata    = hit ? regs_q[idx] : '1;
  assign ctrl_o   = regs_q[IDX_CTRL];
  assign status_o = regs_q[IDX_STAT];
  assign div_o    = regs_q[IDX_DIV][DIV_W-1:0];
  assign div_wr_o = wr_hit && (idx == IDX_W'(IDX_DIV));
endmodule

// File: rtl/uartif_irq.sv
module uartif_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_lvl,
  input  logic set_pls,
  input  logic clr,
  output logic irq
);
  logic held_q, held_d, pls_q, pls_d;

  always_comb begin
    held_d = held_q;
    if (clr)     held_d = 1'b0;
    if (set_lvl) held_d = 1'b1;
    pls_d = set_pls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      pls_q  <= pls_d;
    end
  end

  assign irq = held_q | pls_q;
endmodule

// File: rtl/uartif_baud.sv
module uartif_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk_en,
  input  logic             ext_en,
  input  logic             sel_ext,
  input  logic [DIV_W-1:0] div,
  input  logic             reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d, en;

  assign en = sel_ext ? ext_en : pclk_en;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (reload) begin
      cnt_d = '0;
    end else if (en) begin
      if (cnt_q == div) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/uartif_top.sv
module uartif_top
  import uartif_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pclk_en,
  input  logic              extclk_en,
  output logic              baud_tick,
  output logic              irq_tx,
  output logic              irq_rx
);
  logic [DATA_W-1:0] ctrl_w, status_w;
  logic [DIV_W-1:0]  div_w;
  logic              div_wr_w;
  logic [NIRQ-1:0]   set_lvl_w, set_pls_w, clr_w, irq_w;

  uartif_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rd(bus_rd), .rdata(bus_rdata),
    .ctrl_o(ctrl_w), .status_o(status_w), .div_o(div_w),
    .div_wr_o(div_wr_w), .set_lvl_o(set_lvl_w), .set_pls_o(set_pls_w),
    .clr_o(clr_w)
  );

  for (genvar g = 0; g < NIRQ; g++) begin : g_irq
    uartif_irq u_irq (
      .clk(clk), .rst_n(rst_n), .set_lvl(set_lvl_w[g]),
      .set_pls(set_pls_w[g]), .clr(clr_w[g]), .irq(irq_w[g])
    );
  end

  assign irq_tx = irq_w[IRQ_TX];
  assign irq_rx = irq_w[IRQ_RX];

  uartif_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .ext_en(extclk_en),
    .sel_ext(ctrl_w[CB_EXTCLK]), .div(div_w), .reload(div_wr_w),
    .tick(baud_tick)
  );
endmodule

// File: rtl/uartif_chk.sv
module uartif_chk
  import uartif_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] ctrl,
  input logic [DATA_W-1:0] status,
  input logic [DIV_W-1:0]  div,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              baud_tick
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL * 4);
  localparam logic [ADDR_W-1:0] A_TXH  = ADDR_W'(IDX_TXH * 4);
  localparam logic [ADDR_W-1:0] A_RXH  = ADDR_W'(IDX_RXH * 4);

  // R5
  tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TXH && ctrl[CB_TXLVL]) |=> irq_tx);

  // R5
  tx_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TXH) |=> (status[SB_TXE] && status[SB_TXBE]));

  // R6
  loop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TXH && ctrl[CB_LOOP]) |=> status[SB_RXRDY]);

  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RXH && !bus_wr) |=> !status[SB_RXRDY]);

  // R7
  rx_ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && bus_wdata[CB_RXLVL]) |=> !irq_rx);

  // R3
  unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '1));

  // R8
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && div != '0) |=> !baud_tick);
endmodule

bind uartif_top uartif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .ctrl(ctrl_w), .status(status_w), .div(div_w), .irq_tx(irq_tx),
  .irq_rx(irq_rx), .baud_tick(baud_tick)
);

// File: tb/tb_uartif_top.sv
`timescale 1ns/1ps
module tb_uartif_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        pclk_en, extclk_en;
  logic        baud_tick, irq_tx, irq_rx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uartif_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pclk_en(pclk_en), .extclk_en(extclk_en), .baud_tick(baud_tick),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  localparam logic [7:0] O_LINE = 8'h00, O_CTRL = 8'h04, O_QCFG = 8'h08,
    O_MCFG = 8'h0C, O_STAT = 8'h10, O_ERR = 8'h14, O_TXH = 8'h20,
    O_RXH = 8'h24, O_DIV = 8'h28;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(O_STAT, v); check(v == 32'h6, "R1 status", v, 32'h6);
    rd(O_CTRL, v); check(v == 32'h0, "R1 ctrl", v, 32'h0);
    rd(O_RXH, v);  check(v == 32'h0, "R1 rxh", v, 32'h0);
    rd(O_DIV, v);  check(v == 32'h0, "R1 div", v, 32'h0);
    check(irq_tx == 1'b0 && irq_rx == 1'b0, "R1 irq", {irq_tx, irq_rx}, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(O_LINE, 32'h0000_001B); wr(O_QCFG, 32'hA5A5_0017);
    wr(O_MCFG, 32'h0000_0011); wr(O_ERR, 32'h0000_005A);
    rd(O_LINE, v); check(v == 32'h1B, "R2 line", v, 32'h1B);
    rd(O_QCFG, v); check(v == 32'hA5A5_0017, "R2 qcfg", v, 32'hA5A5_0017);
    rd(O_MCFG, v); check(v == 32'h11, "R2 mcfg", v, 32'h11);
    rd(O_ERR, v);  check(v == 32'h5A, "R2 err", v, 32'h5A);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(8'h2C, v); check(v == 32'hFFFF_FFFF, "R3 read 0x2C", v, 32'hFFFF_FFFF);
    rd(8'h05, v); check(v == 32'hFFFF_FFFF, "R3 read 0x05", v, 32'hFFFF_FFFF);
    wr(8'h40, 32'h0); wr(8'h01, 32'h0); wr(8'h2C, 32'h0);
    rd(O_LINE, v); check(v == 32'h1B, "R3 write ignored", v, 32'h1B);
  endtask

  task automatic t_tx_pulse;
    logic [31:0] v;
    wr(O_CTRL, 32'h0); wr(O_STAT, 32'h0);
    wr(O_TXH, 32'h41);
    check(irq_tx == 1'b1, "R5 tx pulse high", irq_tx, 1);
    @(negedge clk);
    check(irq_tx == 1'b0, "R5 tx pulse low", irq_tx, 0);
    rd(O_STAT, v); check(v == 32'h6, "R5 status", v, 32'h6);
  endtask

  task automatic t_tx_level;
    wr(O_CTRL, 32'h200);
    check(irq_tx == 1'b1, "R7 ctrl bit9 sets tx", irq_tx, 1);
    wr(O_TXH, 32'h42);
    repeat (3) @(negedge clk);
    check(irq_tx == 1'b1, "R5 tx level held", irq_tx, 1);
    wr(O_CTRL, 32'h0);
    check(irq_tx == 1'b0, "R7 ctrl bit9 clear drops tx", irq_tx, 0);
  endtask

  task automatic t_loop_level;
    logic [31:0] v;
    wr(O_CTRL, 32'h120);
    wr(O_TXH, 32'hA5);
    repeat (2) @(negedge clk);
    check(irq_rx == 1'b1, "R6 rx level held", irq_rx, 1);
    rd(O_STAT, v); check(v[0] == 1'b1, "R6 rx ready", v, 32'h7);
    rd(O_RXH, v);  check(v == 32'hA5, "R6 rxh copy", v, 32'hA5);
    check(irq_rx == 1'b0, "R4 read drops rx", irq_rx, 0);
    rd(O_STAT, v); check(v[0] == 1'b0, "R4 ready cleared", v, 32'h6);
  endtask

  task automatic t_loop_pulse;
    logic [31:0] v;
    wr(O_CTRL, 32'h020);
    wr(O_TXH, 32'h3C);
    check(irq_rx == 1'b1, "R6 rx pulse high", irq_rx, 1);
    @(negedge clk);
    check(irq_rx == 1'b0, "R6 rx pulse low", irq_rx, 0);
    rd(O_STAT, v); check(v[0] == 1'b1, "R6 ready pulse mode", v, 32'h7);
    rd(O_RXH, v);  check(v == 32'h3C, "R6 rxh pulse mode", v, 32'h3C);
    rd(O_STAT, v); check(v[0] == 1'b0, "R4 ready cleared pulse mode", v, 32'h6);
  endtask

  task automatic t_ctl_rx_clear;
    wr(O_CTRL, 32'h120);
    wr(O_TXH, 32'h77);
    wr(O_CTRL, 32'h020);
    check(irq_rx == 1'b1, "R7 bit8 clear keeps rx", irq_rx, 1);
    wr(O_CTRL, 32'h120);
    check(irq_rx == 1'b0, "R7 bit8 set drops rx", irq_rx, 0);
  endtask

  task automatic t_baud;
    int n;
    pclk_en = 1'b1; extclk_en = 1'b0;
    wr(O_CTRL, 32'h0); wr(O_DIV, 32'h3);
    n = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (baud_tick) n++; end
    check(n == 10, "R8 bus enable div 3", n, 10);
    wr(O_CTRL, 32'h400); wr(O_DIV, 32'h1);
    n = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (baud_tick) n++; end
    check(n == 0, "R8 external enable idle", n, 0);
    wr(O_DIV, 32'h1);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      extclk_en = (k % 2 == 0);
      @(negedge clk);
      if (baud_tick) n++;
    end
    extclk_en = 1'b0;
    check(n == 10, "R8 external enable div 1", n, 10);
  endtask

  task automatic t_reload;
    int k;
    wr(O_CTRL, 32'h0); wr(O_DIV, 32'h3);
    k = 0;
    while (!baud_tick && k < 20) begin @(negedge clk); k++; end
    wr(O_DIV, 32'h3);
    k = 0;
    while (k < 8) begin
      @(negedge clk); k++;
      if (baud_tick) break;
    end
    check(k == 4, "R9 restart on divisor write", k, 4);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    pclk_en = 1'b1; extclk_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_unmapped();
    t_tx_pulse();
    t_tx_level();
    t_loop_level();
    t_loop_pulse();
    t_ctl_rx_clear();
    t_baud();
    t_reload();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule